// File: doc/BRIEF.md
# Reset and Initialization Sequencer

This block sits between the board's reset sources and an image-sensor timing generator. It divides the system clock into a one-millisecond tick and holds the timing generator in reset, through an active-low output, for as long as a power-on reset or a remote reset request is present. The remote request is a level input that may arrive from another clock domain, so it is synchronized before use.

When every reset source has gone away, the block waits for a programmable number of millisecond ticks. It then sends a single-cycle start pulse to the serial register loader. In the same cycle it latches the output-mode switch (single or dual output), so a change to the switch only takes effect at the next initialization. When the loader reports completion, a ready flag rises. Any new remote request clears the ready flag and the whole sequence starts again from the beginning.

Top module: `init_sequencer`

## Requirements
- R1: `ms_tick_o` is a one-cycle pulse that is high once every `CLK_PER_MS` cycles. Its count restarts from zero when the held-reset condition ends, so the first pulse comes `CLK_PER_MS` cycles after `tg_rst_n_o` rises. It is never high while `tg_rst_n_o` is low.
- R2: While `rst_n` is low, and for the first clock edge after it rises, `tg_rst_n_o`, `loader_start_o`, `ready_o`, `mode_dual_o` and `ms_tick_o` are all 0.
- R3: After `remote_rst_i` goes high, `tg_rst_n_o` goes to 0 at the third rising clock edge (two synchronizer stages plus one state register). It stays 0 while the input stays high.
- R4: After `remote_rst_i` goes low, `tg_rst_n_o` returns to 1 at the third rising clock edge. After `rst_n` is released, it returns to 1 at the first rising edge.
- R5: `loader_start_o` is high for exactly one cycle. Its rising edge comes exactly `DELAY_MS*CLK_PER_MS` clock edges after the edge at which `tg_rst_n_o` rose.
- R6: If a remote request is seen during the delay, no start pulse is issued, even when the request lands on the edge where the delay would have expired. The next release runs the full delay again from zero.
- R7: At the edge that raises `loader_start_o`, `mode_dual_o` takes the value of `mode_sw_i` (1 = dual output, 0 = single output). At all other times it holds that value, whatever the switch does.
- R8: `ready_o` rises one edge after `loader_done_i` is sampled high following a start pulse. `loader_done_i` has no effect during reset or during the delay.
- R9: `ready_o` falls at the same edge at which `tg_rst_n_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| remote_rst_i | input | 1 | Asynchronous, level-driven remote reset request, active high |
| mode_sw_i | input | 1 | Output-mode switch: 1 = dual output, 0 = single output |
| loader_done_i | input | 1 | Register loader has finished programming |
| tg_rst_n_o | output | 1 | Active-low reset to the timing generator |
| loader_start_o | output | 1 | One-cycle pulse that starts the register loader |
| mode_dual_o | output | 1 | Mode latched at the last initialization |
| ready_o | output | 1 | Timing generator has been programmed |
| ms_tick_o | output | 1 | One-millisecond tick pulse |

## Verification
The assertions check four properties on every cycle. The start pulse and the tick are each a single cycle wide. A synchronized remote request forces the reset output low on the next edge and clears the ready flag at the same edge. The latched mode only moves on a start pulse. A start pulse only follows a tick taken while no request was present. The exact cycle counts can only be shown by the bench's scenarios: the delay measured from release, the three-edge synchronizer latency, the phase of the first tick, the abort of a delay that is about to expire, and which switch value is captured.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_HOLD  = 3'd0,
        SEQ_WAIT  = 3'd1,
        SEQ_START = 3'd2,
        SEQ_LOAD  = 3'd3,
        SEQ_READY = 3'd4
    } seq_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/iseq_sync.sv
module iseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
        sync_o = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/iseq_ms_tick.sv
module iseq_ms_tick
    import init_seq_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned W = cnt_width(CLK_PER_MS);
    localparam logic [W-1:0] LAST = W'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        tick_o = !clr_i && (r_q.cnt == LAST);
        if (clr_i || tick_o) r_d.cnt = '0;
        else                 r_d.cnt = r_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    generate
        if (CLK_PER_MS > 1) begin : g_spacing
            // R1
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

    // R1
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (r_q.cnt == '0));
endmodule

// File: rtl/iseq_ctrl.sv
module iseq_ctrl
    import init_seq_pkg::*;
#(
    parameter int unsigned DELAY_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rem_i,
    input  logic tick_i,
    input  logic mode_sw_i,
    input  logic done_i,
    output logic hold_o,
    output logic tg_rst_n_o,
    output logic start_o,
    output logic mode_dual_o,
    output logic ready_o
);
    localparam int unsigned DW = cnt_width(DELAY_MS);
    localparam logic [DW-1:0] DLAST = DW'(DELAY_MS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [DW-1:0] dly;
        logic          mode;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_HOLD: begin
                r_d.dly = '0;
                if (!rem_i) r_d.state = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (rem_i) begin
                    r_d.state = SEQ_HOLD;
                    r_d.dly   = '0;
                end else if (tick_i) begin
                    if (r_q.dly == DLAST) begin
                        r_d.state = SEQ_START;
                        r_d.dly   = '0;
                        r_d.mode  = mode_sw_i;
                    end else begin
                        r_d.dly = r_q.dly + DW'(1);
                    end
                end
            end
            SEQ_START: r_d.state = rem_i ? SEQ_HOLD : SEQ_LOAD;
            SEQ_LOAD: begin
                if (rem_i)       r_d.state = SEQ_HOLD;
                else if (done_i) r_d.state = SEQ_READY;
            end
            SEQ_READY: if (rem_i) r_d.state = SEQ_HOLD;
            default:   r_d.state = SEQ_HOLD;
        endcase
    end

    always_comb begin
        hold_o      = (r_q.state == SEQ_HOLD);
        tg_rst_n_o  = !hold_o;
        start_o     = (r_q.state == SEQ_START);
        ready_o     = (r_q.state == SEQ_READY);
        mode_dual_o = r_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SEQ_HOLD;
            r_q.dly   <= '0;
            r_q.mode  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R3
    hold_on_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_i |=> !tg_rst_n_o);
    // R9
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_i && ready_o) |=> !ready_o);
    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |-> $stable(mode_dual_o));
    // R6
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_o) |-> $past(tick_i && !rem_i));
    // R8
    ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(done_i));
    // R5
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dly <= DLAST);
endmodule

// File: rtl/init_sequencer.sv
module init_sequencer #(
    parameter int unsigned CLK_PER_MS  = 50000,
    parameter int unsigned DELAY_MS    = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic remote_rst_i,
    input  logic mode_sw_i,
    input  logic loader_done_i,
    output logic tg_rst_n_o,
    output logic loader_start_o,
    output logic mode_dual_o,
    output logic ready_o,
    output logic ms_tick_o
);
    logic rem_sync;
    logic hold;
    logic tick;

    iseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (remote_rst_i),
        .sync_o  (rem_sync)
    );

    iseq_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (hold),
        .tick_o (tick)
    );

    iseq_ctrl #(.DELAY_MS(DELAY_MS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rem_i       (rem_sync),
        .tick_i      (tick),
        .mode_sw_i   (mode_sw_i),
        .done_i      (loader_done_i),
        .hold_o      (hold),
        .tg_rst_n_o  (tg_rst_n_o),
        .start_o     (loader_start_o),
        .mode_dual_o (mode_dual_o),
        .ready_o     (ready_o)
    );

    assign ms_tick_o = tick;

    // R9
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tg_rst_n_o |-> (!ready_o && !loader_start_o && !ms_tick_o));
endmodule

// File: tb/init_sequencer_tb.sv
module init_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int D   = 3;
    localparam int DLY = N * D;

    logic clk = 1'b0;
    logic rst_n, remote_rst_i, mode_sw_i, loader_done_i;
    logic tg_rst_n_o, loader_start_o, mode_dual_o, ready_o, ms_tick_o;

    int  vec  = 0;
    int  errs = 0;
    bit  finished = 1'b0;
    logic exp_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    init_sequencer #(.CLK_PER_MS(N), .DELAY_MS(D), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .remote_rst_i(remote_rst_i),
        .mode_sw_i(mode_sw_i), .loader_done_i(loader_done_i),
        .tg_rst_n_o(tg_rst_n_o), .loader_start_o(loader_start_o),
        .mode_dual_o(mode_dual_o), .ready_o(ready_o), .ms_tick_o(ms_tick_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, errs);
    endtask

    // One initialization from the release event; lead = edges until reset output rises
    task automatic run_init(input int lead, input int seed);
        for (int k = 1; k <= lead + DLY; k++) begin
            @(negedge clk);
            check("R4", "tg_rst_n_o", tg_rst_n_o, k >= lead);
            check("R1", "ms_tick_o", ms_tick_o, (k >= lead) && ((k - lead) % N == N - 1));
            check("R5", "loader_start_o", loader_start_o, k == lead + DLY);
            if (k == lead + DLY) exp_mode = mode_sw_i;
            check("R7", "mode_dual_o", mode_dual_o, exp_mode);
            check("R8", "ready_o during delay", ready_o, 1'b0);
            mode_sw_i     = 1'(((k * 7 + seed) >> 1) & 1);
            loader_done_i = (k < lead + DLY - 1) && (k % 2 == 1);
        end
        @(negedge clk);
        check("R5", "start single cycle", loader_start_o, 1'b0);
        check("R8", "ready before done", ready_o, 1'b0);
        loader_done_i = 1'b1;
        @(negedge clk);
        check("R8", "ready after done", ready_o, 1'b1);
        loader_done_i = 1'b0;
        for (int j = 0; j < 4; j++) begin
            mode_sw_i = ~mode_sw_i;
            @(negedge clk);
            check("R7", "mode held in ready", mode_dual_o, exp_mode);
            check("R8", "ready held", ready_o, 1'b1);
        end
    endtask

    task automatic remote_assert();
        remote_rst_i = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R3", "tg_rst_n_o on request", tg_rst_n_o, k < 3);
            check("R9", "ready_o on request", ready_o, k < 3);
        end
        for (int j = 0; j < 6; j++) begin
            mode_sw_i = ~mode_sw_i;
            @(negedge clk);
            check("R3", "tg_rst_n_o held", tg_rst_n_o, 1'b0);
            check("R1", "no tick while held", ms_tick_o, 1'b0);
            check("R9", "ready low while held", ready_o, 1'b0);
            check("R7", "mode ignores switch", mode_dual_o, exp_mode);
        end
    endtask

    initial begin
        rst_n = 1'b0; remote_rst_i = 1'b0; mode_sw_i = 1'b1; loader_done_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "tg_rst_n_o in reset", tg_rst_n_o, 1'b0);
        check("R2", "start in reset", loader_start_o, 1'b0);
        check("R2", "ready in reset", ready_o, 1'b0);
        check("R2", "mode in reset", mode_dual_o, 1'b0);
        check("R2", "tick in reset", ms_tick_o, 1'b0);
        loader_done_i = 1'b0;
        rst_n = 1'b1;
        run_init(1, 0);

        for (int s = 1; s <= 4; s++) begin
            remote_assert();
            remote_rst_i = 1'b0;
            run_init(3, s);
        end

        // R6: request lands on the edge where the delay would expire
        remote_assert();
        remote_rst_i = 1'b0;
        for (int k = 1; k <= DLY; k++) begin
            @(negedge clk);
            check("R6", "no start before abort", loader_start_o, 1'b0);
            check("R4", "tg_rst_n_o released", tg_rst_n_o, k >= 3);
        end
        remote_rst_i = 1'b1;
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            check("R6", "no start after abort", loader_start_o, 1'b0);
            check("R3", "tg_rst_n_o on abort", tg_rst_n_o, j < 3);
        end
        remote_rst_i = 1'b0;
        run_init(3, 9);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule